// File: doc/BRIEF.md
# Two-Level Zero-Overhead Loop Sequencer

This block sits beside the fetch stage of a program controller and runs hardware loops without spending any cycles on them. A loop-start command carries the address of the first instruction of the loop body, the address of the last instruction, and an iteration count. The block saves the body start address on a two-entry last-in-first-out stack and loads its active loop-end and count registers. If an outer loop is already running, its end address and count move first into a second-level register pair.

Each cycle the fetch stage shows the block the address it is fetching. When that address matches the active loop end and more than one iteration remains, the block asserts a redirect in the same cycle. It gives the stacked body start as the next fetch address and lowers the count by one. On the last iteration fetch falls through. The stack pops and the outer loop's end and count return from the second-level registers. A count of zero skips the body: fetch is sent to the end address plus one. A third nested start is refused and a sticky overflow flag is raised.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `depth_o` is 0, `overflow_o` is 0 and `redirect_o` is 0 while no start command is applied.
- R2: A start with a nonzero count while `depth_o` is below 2 pushes `body_addr_i`, so `depth_o` rises by one on the next cycle. `depth_o` never exceeds 2.
- R3: When `fetch_valid_i` is 1, `depth_o` is nonzero, `fetch_addr_i` equals the active loop end and the active count is above 1, then in that same cycle `redirect_o` is 1 and `target_o` is the most recently pushed body address. The active count drops by one.
- R4: When the same match happens with an active count of exactly 1, `redirect_o` stays 0 and `depth_o` falls by one on the next cycle.
- R5: When an inner loop exits, the outer loop's end address and remaining count are restored. The outer loop then iterates and exits at its own end address as if the inner loop had never run.
- R6: A start with a count of 0 sets `redirect_o` to 1 in that same cycle, with `target_o` equal to `end_addr_i` plus one, wrapping at 24 bits. Nothing is pushed and `depth_o` is unchanged.
- R7: A start with a nonzero count while `depth_o` is 2 sets `overflow_o` to 1 on the next cycle. The stack and loop registers are left unchanged, so the running loops continue exactly as before.
- R8: With `fetch_valid_i` at 0, or with `depth_o` at 0, a fetch address equal to any loop end causes no redirect and no change of depth.
- R9: If a start command and a loop-end match occur in the same cycle, only the start takes effect. The match is ignored and the count is not consumed.
- R10: Once set, `overflow_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loop-start command |
| body_addr_i | input | 24 | Address of the first instruction of the loop body |
| end_addr_i | input | 24 | Address of the last instruction of the loop body |
| count_i | input | 16 | Iteration count for the new loop |
| fetch_valid_i | input | 1 | `fetch_addr_i` holds a real fetch this cycle |
| fetch_addr_i | input | 24 | Address being fetched this cycle |
| redirect_o | output | 1 | Next fetch must go to `target_o` instead of the sequential address |
| target_o | output | 24 | Redirect address |
| depth_o | output | 2 | Number of active nested loops |
| overflow_o | output | 1 | Sticky flag: a start was refused because both levels were full |

## Verification
The bench runs a behavioural model built on a queue and plain integers against the block on every cycle. It drives fetch addresses that follow the model's own redirects, so a wrong branch target shows up as a diverging trace.

The corner cases it targets are these:
- Nested loops where the inner exit must hand the outer count back intact. A block that failed to restore would exit the outer loop early or never.
- A zero count at the top of the address space, where the skip target must wrap. A missing wrap would give a 25th-bit overflow or a wrong target.
- A third start at full depth. A block that accepted it would corrupt the outer loop.
- A start landing on the same cycle as a loop-end match. Here a block that honoured both would decrement a count it just loaded.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int ADDR_W  = 24;
  localparam int CNT_W   = 16;
  localparam int LEVELS  = 2;
  localparam int LVL_W   = $clog2(LEVELS + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  // fetch reaches the active loop end
  function automatic logic end_match(input logic valid, input addr_t pc,
                                     input addr_t loop_end, input lvl_t lvl);
    return valid && (lvl != '0) && (pc == loop_end);
  endfunction

  // further iterations remain after this pass
  function automatic logic more_passes(input cnt_t cnt);
    return cnt > cnt_t'(1);
  endfunction

  // fall-through address for a skipped body (wraps)
  function automatic addr_t skip_addr(input addr_t loop_end);
    return loop_end + addr_t'(1);
  endfunction

  function automatic cnt_t count_down(input cnt_t cnt);
    return cnt - cnt_t'(1);
  endfunction
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  input  addr_t data_i,
  output addr_t top_o,
  output lvl_t  level_o
);
  addr_t ent_q [LEVELS];
  lvl_t  level_q;

  for (genvar i = 0; i < LEVELS; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[i] <= '0;
      else if (push_i && level_q == lvl_t'(i))
        ent_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= '0;
    else if (push_i)
      level_q <= level_q + lvl_t'(1);
    else if (pop_i)
      level_q <= level_q - lvl_t'(1);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < LEVELS; i++)
      if (level_q == lvl_t'(i + 1))
        top_o = ent_q[i];
  end

  assign level_o = level_q;
endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs
  import hwloop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  dec_i,
  input  logic  restore_i,
  input  addr_t new_end_i,
  input  cnt_t  new_cnt_i,
  output addr_t end_o,
  output cnt_t  cnt_o
);
  addr_t end_q, end2_q;
  cnt_t  cnt_q, cnt2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= '0;
      cnt_q  <= '0;
      end2_q <= '0;
      cnt2_q <= '0;
    end else if (load_i) begin
      end2_q <= end_q;
      cnt2_q <= cnt_q;
      end_q  <= new_end_i;
      cnt_q  <= new_cnt_i;
    end else if (restore_i) begin
      end_q  <= end2_q;
      cnt_q  <= cnt2_q;
      end2_q <= '0;
      cnt2_q <= '0;
    end else if (dec_i) begin
      cnt_q  <= count_down(cnt_q);
    end
  end

  assign end_o = end_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
(
  input  logic  start_i,
  input  cnt_t  count_i,
  input  addr_t end_addr_i,
  input  logic  fetch_valid_i,
  input  addr_t fetch_addr_i,
  input  addr_t loop_end_i,
  input  cnt_t  loop_cnt_i,
  input  lvl_t  level_i,
  input  addr_t stack_top_i,
  output logic  hit_o,
  output logic  push_o,
  output logic  skip_o,
  output logic  refuse_o,
  output logic  iterate_o,
  output logic  exit_o,
  output logic  redirect_o,
  output addr_t target_o
);
  logic full;
  logic zero_cnt;

  always_comb begin
    full       = (level_i == lvl_t'(LEVELS));
    zero_cnt   = (count_i == '0);
    hit_o      = end_match(fetch_valid_i, fetch_addr_i, loop_end_i, level_i);
    skip_o     = start_i && zero_cnt;
    push_o     = start_i && !zero_cnt && !full;
    refuse_o   = start_i && !zero_cnt && full;
    iterate_o  = !start_i && hit_o && more_passes(loop_cnt_i);
    exit_o     = !start_i && hit_o && !more_passes(loop_cnt_i);
    redirect_o = skip_o || iterate_o;
    target_o   = skip_o ? skip_addr(end_addr_i) : stack_top_i;
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [23:0]       body_addr_i,
  input  logic [23:0]       end_addr_i,
  input  logic [15:0]       count_i,
  input  logic              fetch_valid_i,
  input  logic [23:0]       fetch_addr_i,
  output logic              redirect_o,
  output logic [23:0]       target_o,
  output logic [1:0]        depth_o,
  output logic              overflow_o
);
  addr_t loop_end_w, stack_top_w;
  cnt_t  loop_cnt_w;
  lvl_t  level_w;
  logic  hit_w, push_w, skip_w, refuse_w, iterate_w, exit_w;
  logic  ovf_q;

  hwloop_seq u_seq (
    .start_i       (start_i),
    .count_i       (count_i),
    .end_addr_i    (end_addr_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .loop_end_i    (loop_end_w),
    .loop_cnt_i    (loop_cnt_w),
    .level_i       (level_w),
    .stack_top_i   (stack_top_w),
    .hit_o         (hit_w),
    .push_o        (push_w),
    .skip_o        (skip_w),
    .refuse_o      (refuse_w),
    .iterate_o     (iterate_w),
    .exit_o        (exit_w),
    .redirect_o    (redirect_o),
    .target_o      (target_o)
  );

  hwloop_stack u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_w),
    .pop_i   (exit_w),
    .data_i  (body_addr_i),
    .top_o   (stack_top_w),
    .level_o (level_w)
  );

  hwloop_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (push_w),
    .dec_i     (iterate_w),
    .restore_i (exit_w),
    .new_end_i (end_addr_i),
    .new_cnt_i (count_i),
    .end_o     (loop_end_w),
    .cnt_o     (loop_cnt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else if (refuse_w)
      ovf_q <= 1'b1;
  end

  assign depth_o    = level_w;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        redirect_o,
  input logic [1:0]  depth_o,
  input logic        overflow_o,
  input logic        push_w,
  input logic        skip_w,
  input logic        refuse_w,
  input logic        iterate_w,
  input logic        exit_w,
  input logic [15:0] loop_cnt_w
);
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= 2'd2); // R2
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_w |=> depth_o == $past(depth_o) + 2'd1); // R2
  AST_ITER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    iterate_w |=> loop_cnt_w == $past(loop_cnt_w) - 16'd1); // R3
  AST_EXIT_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_w |=> depth_o == $past(depth_o) - 2'd1); // R4
  AST_SKIP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    skip_w |=> $stable(depth_o)); // R6
  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_w |=> $stable(depth_o) && overflow_o); // R7
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == 2'd0 && !start_i) |-> !redirect_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R10
endmodule

bind hwloop_ctrl hwloop_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .redirect_o (redirect_o),
  .depth_o    (depth_o),
  .overflow_o (overflow_o),
  .push_w     (push_w),
  .skip_w     (skip_w),
  .refuse_w   (refuse_w),
  .iterate_w  (iterate_w),
  .exit_w     (exit_w),
  .loop_cnt_w (loop_cnt_w)
);

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] body_addr_i = '0;
  logic [23:0] end_addr_i = '0;
  logic [15:0] count_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [23:0] fetch_addr_i = '0;
  logic        redirect_o;
  logic [23:0] target_o;
  logic [1:0]  depth_o;
  logic        overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int stk[$];
  int m_end = 0, m_cnt = 0, m_end2 = 0, m_cnt2 = 0;
  bit m_ovf = 0;
  bit e_red;
  int e_tgt;
  int pc;

  always #2 clk = ~clk;

  hwloop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .body_addr_i(body_addr_i),
    .end_addr_i(end_addr_i), .count_i(count_i), .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i(fetch_addr_i), .redirect_o(redirect_o), .target_o(target_o),
    .depth_o(depth_o), .overflow_o(overflow_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, advance model
  task automatic step(input bit st, input int ba, input int ea, input int cnt,
                      input bit fv, input int fa, input string tag);
    bit hit;
    @(negedge clk);
    start_i = st; body_addr_i = ba[23:0]; end_addr_i = ea[23:0]; count_i = cnt[15:0];
    fetch_valid_i = fv; fetch_addr_i = fa[23:0];
    #1;
    hit = fv && stk.size() > 0 && fa == m_end;
    e_red = 0; e_tgt = 0;
    if (st) begin
      if (cnt == 0) begin
        e_red = 1; e_tgt = (ea + 1) & 'hFFFFFF;
      end
    end else if (hit && m_cnt > 1) begin
      e_red = 1; e_tgt = stk[$];
    end
    check(tag, "redirect", int'(redirect_o), int'(e_red));
    if (e_red) check(tag, "target", int'(target_o), e_tgt);
    check(tag, "depth", int'(depth_o), stk.size());
    check(tag, "overflow", int'(overflow_o), int'(m_ovf));
    if (st) begin
      if (cnt != 0) begin
        if (stk.size() < 2) begin
          stk.push_back(ba);
          m_end2 = m_end; m_cnt2 = m_cnt; m_end = ea; m_cnt = cnt;
        end else m_ovf = 1;
      end
    end else if (hit) begin
      if (m_cnt > 1) m_cnt--;
      else begin
        void'(stk.pop_back());
        m_end = m_end2; m_cnt = m_cnt2; m_end2 = 0; m_cnt2 = 0;
      end
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // fetch n addresses, following the model's redirects
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 1, pc, tag);
      pc = e_red ? e_tgt : ((pc + 1) & 'hFFFFFF);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    stk.delete(); m_end = 0; m_cnt = 0; m_end2 = 0; m_cnt2 = 0; m_ovf = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle("R1");
    check("R1", "depth", int'(depth_o), 0);
    check("R1", "overflow", int'(overflow_o), 0);

    // R8: no loop active, valid fetch of arbitrary addresses
    pc = 'h40; run(4, "R8");

    // R2 R3 R4: single loop, 3 passes over 0x100..0x103
    step(1, 'h100, 'h103, 3, 0, 0, "R2");
    pc = 'h100; run(16, "R3");
    check("R4", "depth after loop", int'(depth_o), 0);

    // R8: fetch_valid low at loop end
    step(1, 'h300, 'h302, 2, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 'h302, "R8");
    step(0, 0, 0, 0, 0, 'h302, "R8");
    pc = 'h300; run(8, "R4");

    // R5: nested loops
    step(1, 'h200, 'h210, 2, 0, 0, "R5");
    step(1, 'h205, 'h207, 3, 0, 0, "R5");
    pc = 'h205; run(40, "R5");
    check("R5", "depth after nest", int'(depth_o), 0);

    // R6: zero count skip, including wrap at the top of the space
    step(1, 'h500, 'h520, 0, 0, 0, "R6");
    step(1, 'hFFFFF0, 'hFFFFFF, 0, 0, 0, "R6");
    idle("R6");

    // R9: start coincides with a loop-end match
    step(1, 'h600, 'h602, 2, 0, 0, "R9");
    step(1, 'h700, 'h702, 2, 1, 'h602, "R9");
    pc = 'h700; run(8, "R9");
    pc = 'h600; run(8, "R9");

    // R7 R10: refused third level, running loops unaffected
    step(1, 'h800, 'h80A, 2, 0, 0, "R7");
    step(1, 'h804, 'h805, 2, 0, 0, "R7");
    step(1, 'h900, 'h901, 5, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 'h901, "R7");
    step(1, 'h0, 'h805, 0, 0, 0, "R6");
    pc = 'h804; run(24, "R7");
    idle("R10");
    step(1, 'hA00, 'hA01, 2, 0, 0, "R10");
    pc = 'hA00; run(6, "R10");
    check("R10", "overflow sticky", int'(overflow_o), 1);

    do_reset();
    idle("R1");
    check("R1", "overflow cleared", int'(overflow_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule